// File: doc/BRIEF.md
# Tristate Strobe Advancement Generator

This block drives the external high-impedance strobe of one serial time-division-multiplexed output stream. It keeps its own position in the output frame in quarter-bit steps, because its clock runs at four times the line bit rate. For each position it reads the drive/tristate flag of the channel that the strobe currently covers. The strobe is high for every channel flagged as undriven.

With an advancement code of zero, the strobe lines up with the stream's own channel slots. The stream's channel delay and bit offset are taken in through where the frame pulse is placed. A non-zero code moves the strobe earlier by one to four quarter-bit periods, so that an external buffer can be turned around ahead of the data. At the fastest line rate, only half-bit and whole-bit moves are honoured. An advanced strobe crosses the frame boundary cleanly: the flag of channel 0 can show up in the last quarters of the previous frame.

The flag store sits outside the block. The block presents a channel number on a lookup port and takes back that channel's flag in the same cycle.

Top module: `hiz_strobe_adv`

## Requirements
- R1: While `rst` is high at a clock edge, `hiz_o` is 0 after that edge.
- R2: The clock cycle after the edge that samples `frm_i` high is quarter slot 0 of the frame. A pulse in the middle of a frame restarts the count at slot 0.
- R3: With code 0, `hiz_o` in quarter slot p equals the flag of channel floor(p/32). Each channel spans 32 quarter slots (8 bits of 4 quarters each), so the strobe is aligned to the channel slots of the output frame.
- R4: At rate codes 0, 1 and 2, advancement codes 1, 2, 3 and 4 move the strobe earlier by that many quarter slots. In quarter slot p, `hiz_o` shows the flag of channel floor(((p+code) mod L)/32), where L is the frame length in quarter slots.
- R5: At rate code 3 (the fastest line rate), codes 2 and 4 advance the strobe by 2 and 4 quarter slots. Codes 1 and 3 give no advancement.
- R6: Advancement codes 5, 6 and 7 give no advancement at every rate.
- R7: Rate codes 0, 1, 2 and 3 select frames of 32, 64, 128 and 256 channels, so L = 1024, 2048, 4096 and 8192 quarter slots. Without a frame pulse, the position wraps from L-1 to 0 on its own.
- R8: The advanced lookahead wraps across the frame boundary. With code 4, quarter slots L-4 to L-1 show the flag of channel 0, and slot L-5 shows the flag of the last channel.
- R9: `look_ch_o` names the channel whose flag `look_hiz_i` returns in the same cycle. That flag appears on `hiz_o` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the line bit rate |
| rst | input | 1 | Synchronous active-high reset |
| frm_i | input | 1 | Output frame pulse; the next cycle is quarter slot 0 |
| rate_i | input | 2 | Line rate select, 0 slowest to 3 fastest |
| adv_code_i | input | 3 | Strobe advancement code |
| look_ch_o | output | 8 | Channel whose tristate flag is requested |
| look_hiz_i | input | 1 | Tristate flag of the requested channel (1 = undriven) |
| hiz_o | output | 1 | High-impedance strobe |

## Verification
Two functions can act in the same cycle: a frame pulse restarting the slot count, and the advanced lookahead wrapping past the end of the frame into channel 0. The bench issues each frame pulse in the very slot where the count would wrap on its own. It also sends one pulse in mid-frame, and runs one frame with no pulse at all. A behavioural model tracks the slot position as a plain integer and takes the lookahead modulo the frame length. That model judges `hiz_o` on every clock, and directed checks at slots L-5 and L-1 pin down the wrap of channel 0's flag.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    localparam int unsigned QTR_PER_BIT = 4;
    localparam int unsigned ADV_CODE_W  = 3;
    localparam int unsigned ADV_W       = 3;
    localparam int unsigned MAX_ADV     = 4;

    typedef logic [ADV_CODE_W-1:0] adv_code_t;
    typedef logic [ADV_W-1:0]      adv_qtr_t;

    typedef struct packed {
        adv_code_t code;
        logic      half_only;
    } adv_req_t;

    // Map a code to a quarter-bit advancement; odd quarters dropped when only
    // half-bit resolution is available.
    function automatic adv_qtr_t adv_quarters(adv_req_t req);
        adv_qtr_t q;
        if (req.code <= adv_code_t'(MAX_ADV)) q = adv_qtr_t'(req.code);
        else                                  q = '0;
        if (req.half_only && q[0])            q = '0;
        return q;
    endfunction

endpackage

// File: rtl/hsa_adv_decode.sv
module hsa_adv_decode
    import hsa_pkg::*;
#(
    parameter int unsigned RATE_W    = 2,
    parameter int unsigned FAST_RATE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_i,
    input  adv_code_t         code_i,
    output adv_qtr_t          adv_o
);

    adv_req_t req;

    always_comb begin
        req.code      = code_i;
        req.half_only = (rate_i == RATE_W'(FAST_RATE));
        adv_o         = adv_quarters(req);
    end

    AST_ADV_MAX: assert property (@(posedge clk) disable iff (rst)
        adv_o <= adv_qtr_t'(MAX_ADV)); // R4
    AST_FAST_HALF_STEPS: assert property (@(posedge clk) disable iff (rst)
        (rate_i == RATE_W'(FAST_RATE)) |-> (adv_o[0] == 1'b0)); // R5
    AST_HIGH_CODES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (code_i > adv_code_t'(MAX_ADV)) |-> (adv_o == '0)); // R6

endmodule

// File: rtl/hsa_slot_counter.sv
module hsa_slot_counter #(
    parameter int unsigned POS_W = 13,
    localparam int unsigned LEN_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_i,
    input  logic [LEN_W-1:0] frame_len_i,
    output logic [POS_W-1:0] pos_nxt_o
);

    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] pos_inc;

    always_comb begin
        pos_inc = {1'b0, pos_q} + LEN_W'(1);
        if (frm_i || pos_inc >= frame_len_i) pos_nxt_o = '0;
        else                                 pos_nxt_o = pos_inc[POS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_nxt_o;
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        frm_i |=> (pos_q == '0)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!frm_i && ({1'b0, pos_q} == frame_len_i - LEN_W'(1))) |=> (pos_q == '0)); // R7
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!frm_i && (pos_inc < frame_len_i)) |=> (pos_q == $past(pos_q) + POS_W'(1))); // R7

endmodule

// File: rtl/hsa_lookahead.sv
module hsa_lookahead
    import hsa_pkg::*;
#(
    parameter int unsigned POS_W   = 13,
    parameter int unsigned SLOT_SH = 5,
    localparam int unsigned LEN_W  = POS_W + 1,
    localparam int unsigned CH_W   = POS_W - SLOT_SH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_nxt_i,
    input  adv_qtr_t         adv_i,
    input  logic [LEN_W-1:0] frame_len_i,
    output logic [CH_W-1:0]  look_ch_o,
    input  logic             look_hiz_i,
    output logic             hiz_o
);

    logic [LEN_W-1:0] la_raw;
    logic [LEN_W-1:0] la_w;

    always_comb begin
        la_raw = {1'b0, pos_nxt_i} + LEN_W'(adv_i);
        if (la_raw >= frame_len_i) la_w = la_raw - frame_len_i;
        else                       la_w = la_raw;
        look_ch_o = la_w[POS_W-1:SLOT_SH];
    end

    always_ff @(posedge clk) begin
        if (rst) hiz_o <= 1'b0;
        else     hiz_o <= look_hiz_i;
    end

    AST_LOOK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        la_w < frame_len_i); // R8
    AST_ZERO_ADV_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (adv_i == '0) |-> (look_ch_o == pos_nxt_i[POS_W-1:SLOT_SH])); // R3

endmodule

// File: rtl/hiz_strobe_adv.sv
module hiz_strobe_adv
    import hsa_pkg::*;
#(
    parameter int unsigned BASE_CH     = 32,
    parameter int unsigned BITS_PER_CH = 8,
    parameter int unsigned N_RATES     = 4,
    localparam int unsigned RATE_W     = $clog2(N_RATES),
    localparam int unsigned CH_MAX     = BASE_CH << (N_RATES - 1),
    localparam int unsigned SLOT_QTR   = BITS_PER_CH * QTR_PER_BIT,
    localparam int unsigned SLOT_SH    = $clog2(SLOT_QTR),
    localparam int unsigned POS_W      = $clog2(CH_MAX * SLOT_QTR),
    localparam int unsigned LEN_W      = POS_W + 1,
    localparam int unsigned CH_W       = POS_W - SLOT_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [2:0]        adv_code_i,
    output logic [CH_W-1:0]   look_ch_o,
    input  logic              look_hiz_i,
    output logic              hiz_o
);

    logic [LEN_W-1:0] len_tab [N_RATES];
    logic [LEN_W-1:0] frame_len;
    logic [POS_W-1:0] pos_nxt;
    adv_qtr_t         adv;

    for (genvar g = 0; g < N_RATES; g++) begin : g_len
        assign len_tab[g] = LEN_W'((BASE_CH << g) * SLOT_QTR);
    end

    assign frame_len = len_tab[rate_i];

    hsa_slot_counter #(.POS_W(POS_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frm_i      (frm_i),
        .frame_len_i(frame_len),
        .pos_nxt_o  (pos_nxt)
    );

    hsa_adv_decode #(.RATE_W(RATE_W), .FAST_RATE(N_RATES - 1)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .rate_i(rate_i),
        .code_i(adv_code_i),
        .adv_o (adv)
    );

    hsa_lookahead #(.POS_W(POS_W), .SLOT_SH(SLOT_SH)) u_look (
        .clk        (clk),
        .rst        (rst),
        .pos_nxt_i  (pos_nxt),
        .adv_i      (adv),
        .frame_len_i(frame_len),
        .look_ch_o  (look_ch_o),
        .look_hiz_i (look_hiz_i),
        .hiz_o      (hiz_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !hiz_o); // R1

endmodule

// File: tb/hiz_strobe_adv_bench.sv
module hiz_strobe_adv_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm = 1'b0;
    logic [1:0] rate = 2'd0;
    logic [2:0] code = 3'd0;
    logic [7:0] look_ch;
    logic       look_hiz;
    logic       hiz;

    bit flags [256];

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string cur_req = "R3";

    int mpos = 0;
    bit exp_hiz = 0;

    always #5 clk = ~clk;

    assign look_hiz = flags[look_ch];

    hiz_strobe_adv u_hiz_strobe_adv (
        .clk       (clk),
        .rst       (rst),
        .frm_i     (frm),
        .rate_i    (rate),
        .adv_code_i(code),
        .look_ch_o (look_ch),
        .look_hiz_i(look_hiz),
        .hiz_o     (hiz)
    );

    function automatic int ref_adv(int c, int r);
        if (c > 4) return 0;
        if (r == 3 && (c == 1 || c == 3)) return 0;
        return c;
    endfunction

    function automatic int frame_q(int r);
        return (32 << r) * 32;
    endfunction

    // behavioural reference: integer slot position, lookahead modulo frame
    always @(posedge clk) begin
        if (rst) begin
            mpos = 0;
            exp_hiz = 0;
        end else begin
            int L, npos, la;
            L = frame_q(int'(rate));
            if (frm) npos = 0;
            else npos = (mpos + 1 >= L) ? 0 : mpos + 1;
            la = (npos + ref_adv(int'(code), int'(rate))) % L;
            exp_hiz = flags[la / 32];
            mpos = npos;
        end
    end

    task automatic check(string req, bit act, bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: hiz_o=%0b expected %0b at slot %0d", req, act, exp, mpos);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) check(cur_req, hiz, exp_hiz);
    endtask

    task automatic set_flags(int seed);
        for (int c = 0; c < 256; c++) flags[c] = (((c * 5 + seed) % 3) == 0);
    endtask

    // one frame: pulse, then run to slot L-1 (next pulse lands on the wrap)
    task automatic run_frame(int r, int c, bit pulse);
        rate = 2'(r);
        code = 3'(c);
        frm = pulse;
        tick();
        frm = 1'b0;
        for (int i = 1; i < frame_q(r); i++) tick();
    endtask

    function automatic string tag_for(int r, int c);
        if (c == 0) return "R3";
        if (c > 4) return "R6";
        if (r == 3) return "R5";
        return "R4";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        set_flags(1);
        repeat (3) @(negedge clk);
        check("R1", hiz, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 8; c++) begin
                set_flags(r + c);
                cur_req = tag_for(r, c);
                run_frame(r, c, 1'b1);
            end
        end

        // R7: a second frame with no pulse, count wraps on its own
        set_flags(2);
        cur_req = "R7";
        run_frame(1, 2, 1'b1);
        run_frame(1, 2, 1'b0);

        // R2: pulse in the middle of a frame restarts at slot 0
        cur_req = "R2";
        rate = 2'd0; code = 3'd0;
        frm = 1'b1; tick(); frm = 1'b0;
        for (int i = 0; i < 100; i++) tick();
        frm = 1'b1; tick(); frm = 1'b0;
        for (int i = 1; i < 1024; i++) tick();

        // R8: only channel 0 flagged, code 4, flag leaks into end of frame
        for (int ch = 0; ch < 256; ch++) flags[ch] = (ch == 0);
        cur_req = "R8";
        rate = 2'd0; code = 3'd4;
        frm = 1'b1; tick(); frm = 1'b0;
        for (int i = 1; i < 1024; i++) begin
            tick();
            if (i == 1019) check("R8", hiz, 1'b0);
            if (i == 1020) check("R8", hiz, 1'b1);
            if (i == 1023) check("R8", hiz, 1'b1);
        end
        frm = 1'b1; tick(); frm = 1'b0;
        check("R8", hiz, 1'b1);

        // R9: lookup channel tracks slot; one channel flag reaches hiz_o next edge
        for (int ch = 0; ch < 256; ch++) flags[ch] = (ch == 5);
        cur_req = "R9";
        code = 3'd0;
        for (int i = 1; i < 1024; i++) begin
            tick();
            if (i == 159) check("R9", hiz, 1'b0);
            if (i == 160) check("R9", hiz, 1'b1);
            if (i == 191) check("R9", hiz, 1'b1);
            if (i == 192) check("R9", hiz, 1'b0);
        end

        // R1: reset mid-run clears the strobe
        for (int ch = 0; ch < 256; ch++) flags[ch] = 1'b1;
        tick();
        rst = 1'b1;
        @(negedge clk);
        check("R1", hiz, 1'b0);
        rst = 1'b0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule